// File: doc/BRIEF.md
# Operand Address Resolver

This unit sits between the instruction decoder and the execute stage of a small 8-bit processor with a 16-bit address space. The decoder hands it an addressing-mode code together with the program counter, the two index registers and the accumulator. The resolver then walks through the instruction's operand bytes and any pointer bytes over a single byte-wide read port. When it finishes it presents the effective address, the operand byte, the program counter advanced past the operand bytes, a flag that selects the accumulator as the operand, and a flag that marks an index addition crossing a page.

The unit copies the processor's address wraparound behaviour exactly. An indexed zero-page address never leaves page zero. A pointer held in page zero wraps inside page zero. The high byte of an indirect-jump pointer is read from the same page as its low byte. One request runs at a time. The request is accepted in a cycle where `start` is high and the unit is idle, and completion is marked by a one-cycle `done`.

Top module: `eff_addr_gen`

## Requirements
- R1: A request is taken only when `busy` is low and `start` is high. Mode, PC, X, Y and accumulator are captured at that edge. `busy` stays high until `done` has been shown. Changes on `start` or on the request inputs while `busy` is high have no effect on the result or on the memory reads.
- R2: `done` is high for exactly one cycle. Counting clock edges after the accepting edge, it rises after 1 edge for modes 0, 1 and 13 to 15; after 2 for modes 2 and 6; after 3 for modes 3 to 5; after 4 for modes 7 to 9; after 5 for modes 11 and 12; and after 6 for mode 10. The results hold until the next request is accepted.
- R3: Mode codes on `mode_in` (4 bits) are: 0 none, 1 accumulator, 2 immediate, 3 zero page, 4 zero page + X, 5 zero page + Y, 6 relative, 7 absolute, 8 absolute + X, 9 absolute + Y, 10 indirect, 11 pre-indexed indirect (X), 12 post-indexed indirect (Y). Codes 13 to 15 behave as code 0.
- R4: For mode 0 (and codes 13 to 15), no memory read occurs, `ea` and `operand` are 0, and `pc_out` equals the captured PC.
- R5: For mode 1, no memory read occurs, `operand` equals the captured accumulator, `ea` is 0 and `acc_sel` is 1. For every other mode `acc_sel` is 0.
- R6: For mode 2, `ea` equals the captured PC and `pc_out` is PC+1.
- R7: For modes 3 to 5, one byte b is read at PC and `ea` = {8'h00, (b + idx) mod 256}, where idx is 0, X or Y. `pc_out` is PC+1.
- R8: For mode 6, the offset byte at PC is returned in `ea` with bit 7 copied into all of bits 15:8. `pc_out` is PC+1 and `operand` is 0.
- R9: For modes 7 to 9, the low byte is read at PC and the high byte at PC+1 (16-bit wrap). `ea` is that base plus 0, X or Y, modulo 65536. `pc_out` is PC+2.
- R10: For mode 10, the pointer P comes from PC and PC+1. The low byte of `ea` is read at P and the high byte at {P[15:8], P[7:0]+1 mod 256}.
- R11: For mode 11, z = (b + X) mod 256. The `ea` low byte is read at {8'h00, z} and the high byte at {8'h00, (z+1) mod 256}. `pc_out` is PC+1.
- R12: For mode 12, the pointer low byte is read at {8'h00, b} and the high byte at {8'h00, (b+1) mod 256}. `ea` = pointer + Y modulo 65536. `pc_out` is PC+1.
- R13: `page_cross` is 1 exactly when, in modes 8, 9 or 12, adding the index to the low byte of the base carries out of bit 7. Otherwise it is 0.
- R14: Every mode except 0, 1 and 6 ends with a read at `ea` whose data becomes `operand`. Reads happen in the order operand bytes, then pointer bytes, then the operand, one per cycle, with `mem_rd` high and the address on `mem_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, taken while idle |
| mode_in | input | 4 | Addressing-mode code (R3) |
| pc_in | input | 16 | Program counter pointing at the first operand byte |
| x_in | input | 8 | X index register |
| y_in | input | 8 | Y index register |
| acc_in | input | 8 | Accumulator value |
| mem_rd | output | 1 | Read strobe for the byte port |
| mem_addr | output | 16 | Read address, 0 when no read |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 16 | Effective address |
| operand | output | 8 | Operand byte |
| pc_out | output | 16 | Program counter after the operand bytes |
| acc_sel | output | 1 | The operand is the accumulator |
| page_cross | output | 1 | The indexed addition crossed a page |

## Verification
The assertions assume that the read port returns data combinationally in the cycle the address is presented. They also assume that reset is held for at least two clock edges before any request, so that the synchronised reset has released before `start` is sampled. The bench models memory as a pure function of the address plus a table of overrides, and changes that table only while the unit is idle. Every byte the model predicts is therefore the byte the unit sees. Requests are issued only after reset has settled. One run holds `start` high with scrambled request inputs for its whole duration, to show that they are ignored.

// File: rtl/eag_pkg.sv
package eag_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MD_NONE    = 4'd0;
  localparam logic [MODE_W-1:0] MD_ACCUM   = 4'd1;
  localparam logic [MODE_W-1:0] MD_IMMED   = 4'd2;
  localparam logic [MODE_W-1:0] MD_ZP      = 4'd3;
  localparam logic [MODE_W-1:0] MD_ZPX     = 4'd4;
  localparam logic [MODE_W-1:0] MD_ZPY     = 4'd5;
  localparam logic [MODE_W-1:0] MD_BRANCH  = 4'd6;
  localparam logic [MODE_W-1:0] MD_ABS     = 4'd7;
  localparam logic [MODE_W-1:0] MD_ABSX    = 4'd8;
  localparam logic [MODE_W-1:0] MD_ABSY    = 4'd9;
  localparam logic [MODE_W-1:0] MD_INDIR   = 4'd10;
  localparam logic [MODE_W-1:0] MD_PREIDX  = 4'd11;
  localparam logic [MODE_W-1:0] MD_POSTIDX = 4'd12;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OP0  = 3'd1,
    ST_OP1  = 3'd2,
    ST_PTR0 = 3'd3,
    ST_PTR1 = 3'd4,
    ST_DATA = 3'd5,
    ST_DONE = 3'd6
  } state_e;

  function automatic logic is_zp_class(input logic [MODE_W-1:0] m);
    return (m == MD_ZP) || (m == MD_ZPX) || (m == MD_ZPY);
  endfunction

  function automatic logic is_zp_ptr(input logic [MODE_W-1:0] m);
    return (m == MD_PREIDX) || (m == MD_POSTIDX);
  endfunction

  function automatic logic is_two_byte(input logic [MODE_W-1:0] m);
    return (m == MD_ABS) || (m == MD_ABSX) || (m == MD_ABSY) || (m == MD_INDIR);
  endfunction

endpackage

// File: rtl/eag_idx_add.sv
module eag_idx_add #(
  parameter int DATA_W = 8,
  parameter bit WRAP   = 1'b0
) (
  input  logic [2*DATA_W-1:0] base,
  input  logic [DATA_W-1:0]   idx,
  output logic [2*DATA_W-1:0] sum,
  output logic                carry
);
  localparam int ADDR_W = 2 * DATA_W;

  logic [DATA_W:0] low_ext;

  always_comb begin
    low_ext = {1'b0, base[DATA_W-1:0]} + {1'b0, idx};
    carry   = low_ext[DATA_W];
  end

  generate
    if (WRAP) begin : g_page_wrap
      always_comb sum = {base[ADDR_W-1:DATA_W], low_ext[DATA_W-1:0]};
    end else begin : g_full_add
      always_comb sum = {base[ADDR_W-1:DATA_W] + {{(DATA_W-1){1'b0}}, low_ext[DATA_W]},
                         low_ext[DATA_W-1:0]};
    end
  endgenerate

endmodule

// File: rtl/eag_ctrl.sv
module eag_ctrl
  import eag_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [MODE_W-1:0] mode_q,
  output state_e            state_q
);

  state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load) begin
          if (mode_in == MD_IMMED)                           state_d = ST_DATA;
          else if (is_zp_class(mode_in) || is_zp_ptr(mode_in) ||
                   is_two_byte(mode_in) || mode_in == MD_BRANCH) state_d = ST_OP0;
          else                                               state_d = ST_DONE;
        end
      end
      ST_OP0: begin
        if (mode_q == MD_BRANCH)      state_d = ST_DONE;
        else if (is_zp_class(mode_q)) state_d = ST_DATA;
        else if (is_zp_ptr(mode_q))   state_d = ST_PTR0;
        else                          state_d = ST_OP1;
      end
      ST_OP1:  state_d = (mode_q == MD_INDIR) ? ST_PTR0 : ST_DATA;
      ST_PTR0: state_d = ST_PTR1;
      ST_PTR1: state_d = ST_DATA;
      ST_DATA: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/eag_dpath.sv
module eag_dpath
  import eag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  state_e              state_q,
  input  logic                load,
  input  logic [MODE_W-1:0]   mode_in,
  input  logic [2*DATA_W-1:0] pc_in,
  input  logic [DATA_W-1:0]   x_in,
  input  logic [DATA_W-1:0]   y_in,
  input  logic [DATA_W-1:0]   acc_in,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [MODE_W-1:0]   mode_q,
  output logic                mem_rd,
  output logic [2*DATA_W-1:0] mem_addr,
  output logic [2*DATA_W-1:0] ea_q,
  output logic [DATA_W-1:0]   opnd_q,
  output logic [2*DATA_W-1:0] pc_q,
  output logic                acc_sel_q,
  output logic                cross_q
);
  localparam int ADDR_W = 2 * DATA_W;
  localparam logic [ADDR_W-1:0] ONE_A = {{(ADDR_W-1){1'b0}}, 1'b1};
  localparam logic [DATA_W-1:0] ONE_D = {{(DATA_W-1){1'b0}}, 1'b1};

  logic [DATA_W-1:0] x_q, y_q, lo_q;
  logic [ADDR_W-1:0] ptr_q;

  logic [DATA_W-1:0] zp_idx, ab_idx;
  logic [ADDR_W-1:0] zp_sum, ab_sum, pinc_sum;
  logic              ab_carry, zp_carry_unused, pinc_carry_unused;

  logic              pc_en, ea_en, ptr_en, lo_en, opnd_en, acc_en, cross_en;
  logic [ADDR_W-1:0] pc_d, ea_d, ptr_d;
  logic [DATA_W-1:0] opnd_d;
  logic              acc_d, cross_d;

  always_comb begin
    if (mode_q == MD_ZPY)                           zp_idx = y_q;
    else if (mode_q == MD_ZPX || mode_q == MD_PREIDX) zp_idx = x_q;
    else                                            zp_idx = '0;
    if (mode_q == MD_ABSX)                          ab_idx = x_q;
    else if (mode_q == MD_ABSY || mode_q == MD_POSTIDX) ab_idx = y_q;
    else                                            ab_idx = '0;
  end

  eag_idx_add #(.DATA_W(DATA_W), .WRAP(1'b1)) u_zp_add (
    .base  ({{DATA_W{1'b0}}, mem_rdata}),
    .idx   (zp_idx),
    .sum   (zp_sum),
    .carry (zp_carry_unused)
  );

  eag_idx_add #(.DATA_W(DATA_W), .WRAP(1'b0)) u_ab_add (
    .base  ({mem_rdata, lo_q}),
    .idx   (ab_idx),
    .sum   (ab_sum),
    .carry (ab_carry)
  );

  eag_idx_add #(.DATA_W(DATA_W), .WRAP(1'b1)) u_ptr_inc (
    .base  (ptr_q),
    .idx   (ONE_D),
    .sum   (pinc_sum),
    .carry (pinc_carry_unused)
  );

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = '0;
    unique case (state_q)
      ST_OP0, ST_OP1: begin mem_rd = 1'b1; mem_addr = pc_q;     end
      ST_PTR0:        begin mem_rd = 1'b1; mem_addr = ptr_q;    end
      ST_PTR1:        begin mem_rd = 1'b1; mem_addr = pinc_sum; end
      ST_DATA:        begin mem_rd = 1'b1; mem_addr = ea_q;     end
      default:        begin mem_rd = 1'b0; mem_addr = '0;       end
    endcase
  end

  always_comb begin
    pc_en = 1'b0;    pc_d = pc_q;
    ea_en = 1'b0;    ea_d = ea_q;
    ptr_en = 1'b0;   ptr_d = ptr_q;
    lo_en = 1'b0;
    opnd_en = 1'b0;  opnd_d = opnd_q;
    acc_en = 1'b0;   acc_d = acc_sel_q;
    cross_en = 1'b0; cross_d = cross_q;
    unique case (state_q)
      ST_IDLE: begin
        if (load) begin
          pc_en    = 1'b1;
          pc_d     = (mode_in == MD_IMMED) ? pc_in + ONE_A : pc_in;
          ea_en    = 1'b1;
          ea_d     = (mode_in == MD_IMMED) ? pc_in : '0;
          opnd_en  = 1'b1;
          opnd_d   = (mode_in == MD_ACCUM) ? acc_in : '0;
          acc_en   = 1'b1;
          acc_d    = (mode_in == MD_ACCUM);
          cross_en = 1'b1;
          cross_d  = 1'b0;
        end
      end
      ST_OP0: begin
        pc_en = 1'b1;
        pc_d  = pc_q + ONE_A;
        lo_en = 1'b1;
        if (is_zp_class(mode_q)) begin
          ea_en = 1'b1;
          ea_d  = zp_sum;
        end
        if (mode_q == MD_BRANCH) begin
          ea_en = 1'b1;
          ea_d  = {{DATA_W{mem_rdata[DATA_W-1]}}, mem_rdata};
        end
        if (is_zp_ptr(mode_q)) begin
          ptr_en = 1'b1;
          ptr_d  = zp_sum;
        end
      end
      ST_OP1: begin
        pc_en = 1'b1;
        pc_d  = pc_q + ONE_A;
        if (mode_q == MD_INDIR) begin
          ptr_en = 1'b1;
          ptr_d  = ab_sum;
        end else begin
          ea_en    = 1'b1;
          ea_d     = ab_sum;
          cross_en = 1'b1;
          cross_d  = ab_carry;
        end
      end
      ST_PTR0: lo_en = 1'b1;
      ST_PTR1: begin
        ea_en    = 1'b1;
        ea_d     = ab_sum;
        cross_en = 1'b1;
        cross_d  = ab_carry;
      end
      ST_DATA: begin
        opnd_en = 1'b1;
        opnd_d  = mem_rdata;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= MD_NONE;
      x_q       <= '0;
      y_q       <= '0;
      lo_q      <= '0;
      ptr_q     <= '0;
      pc_q      <= '0;
      ea_q      <= '0;
      opnd_q    <= '0;
      acc_sel_q <= 1'b0;
      cross_q   <= 1'b0;
    end else begin
      if (load) begin
        mode_q <= mode_in;
        x_q    <= x_in;
        y_q    <= y_in;
      end
      if (lo_en)    lo_q      <= mem_rdata;
      if (ptr_en)   ptr_q     <= ptr_d;
      if (pc_en)    pc_q      <= pc_d;
      if (ea_en)    ea_q      <= ea_d;
      if (opnd_en)  opnd_q    <= opnd_d;
      if (acc_en)   acc_sel_q <= acc_d;
      if (cross_en) cross_q   <= cross_d;
    end
  end

endmodule

// File: rtl/eff_addr_gen.sv
module eff_addr_gen
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [MODE_W-1:0] mode_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] y_in,
  input  logic [DATA_W-1:0] acc_in,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] ea,
  output logic [DATA_W-1:0] operand,
  output logic [ADDR_W-1:0] pc_out,
  output logic              acc_sel,
  output logic              page_cross
);

  logic              rst_meta_n, rst_sync_n;
  state_e            state_q;
  logic [MODE_W-1:0] mode_q;
  logic              load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  always_comb begin
    busy = (state_q != ST_IDLE);
    done = (state_q == ST_DONE);
    load = start && (state_q == ST_IDLE);
  end

  eag_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load    (load),
    .mode_in (mode_in),
    .mode_q  (mode_q),
    .state_q (state_q)
  );

  eag_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .state_q   (state_q),
    .load      (load),
    .mode_in   (mode_in),
    .pc_in     (pc_in),
    .x_in      (x_in),
    .y_in      (y_in),
    .acc_in    (acc_in),
    .mem_rdata (mem_rdata),
    .mode_q    (mode_q),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .ea_q      (ea),
    .opnd_q    (operand),
    .pc_q      (pc_out),
    .acc_sel_q (acc_sel),
    .cross_q   (page_cross)
  );

endmodule

// File: rtl/eag_checker.sv
module eag_checker
  import eag_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [ADDR_W-1:0] ea,
  input logic              acc_sel,
  input logic [MODE_W-1:0] mode_q,
  input state_e            state_q
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (mode_q == $past(mode_q))); // R1

  AST_READ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> busy); // R14

  AST_NO_READ_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (mode_q == MD_NONE || mode_q == MD_ACCUM)) |-> !mem_rd); // R4

  AST_ACC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (acc_sel == (mode_q == MD_ACCUM))); // R5

  AST_ZP_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_zp_class(mode_q)) |-> (ea[ADDR_W-1:DATA_W] == '0)); // R7

  AST_PTR_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PTR1) |-> (mem_addr[ADDR_W-1:DATA_W] == $past(mem_addr[ADDR_W-1:DATA_W]))); // R10

endmodule

bind eff_addr_gen eag_checker #(.DATA_W(DATA_W)) u_eag_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_rd   (mem_rd),
  .mem_addr (mem_addr),
  .ea       (ea),
  .acc_sel  (acc_sel),
  .mode_q   (mode_q),
  .state_q  (state_q)
);

// File: tb/eff_addr_gen_bench.sv
module eff_addr_gen_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode_i = '0;
  logic [15:0] pc_i = '0;
  logic [7:0]  x_i = '0, y_i = '0, a_i = '0;
  logic        mem_rd, busy, done, acc_sel, page_cross;
  logic [15:0] mem_addr, ea, pc_out;
  logic [7:0]  mem_rdata, operand;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  bit [7:0] ovr [bit [15:0]];

  function automatic logic [7:0] rd_byte(input logic [15:0] a);
    if (ovr.exists(a)) return ovr[a];
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  assign mem_rdata = rd_byte(mem_addr);

  always #(CLK_P/2) clk = ~clk;

  eff_addr_gen u_eff_addr_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode_i), .pc_in(pc_i),
    .x_in(x_i), .y_in(y_i), .acc_in(a_i), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .ea(ea), .operand(operand),
    .pc_out(pc_out), .acc_sel(acc_sel), .page_cross(page_cross)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Behavioural model: expected reads, latency and results, then a per-cycle compare.
  task automatic run_op(input string req, input int mode, input logic [15:0] pc,
                        input logic [7:0] x, input logic [7:0] y, input logic [7:0] a,
                        input bit noisy);
    logic [15:0] reads[$];
    logic [15:0] e_ea = 16'h0, e_pc = pc, ptr, base;
    logic [7:0]  e_op = 8'h0, b, z;
    logic        e_acc = 0, e_cross = 0;
    int          lat;
    reads.delete();
    case (mode)
      1: begin e_op = a; e_acc = 1; end
      2: begin e_ea = pc; e_pc = pc + 16'd1; end
      3, 4, 5: begin
        b = rd_byte(pc); reads.push_back(pc); e_pc = pc + 16'd1;
        e_ea = {8'h00, b + ((mode == 4) ? x : (mode == 5) ? y : 8'h00)};
      end
      6: begin
        b = rd_byte(pc); reads.push_back(pc); e_pc = pc + 16'd1;
        e_ea = (b >= 8'h80) ? {8'hFF, b} : {8'h00, b};
      end
      7, 8, 9, 10: begin
        reads.push_back(pc); reads.push_back(pc + 16'd1);
        base = {rd_byte(pc + 16'd1), rd_byte(pc)};
        e_pc = pc + 16'd2;
        if (mode == 10) begin
          ptr = base;
          reads.push_back(ptr);
          reads.push_back({ptr[15:8], ptr[7:0] + 8'd1});
          e_ea = {rd_byte({ptr[15:8], ptr[7:0] + 8'd1}), rd_byte(ptr)};
        end else begin
          int idx = (mode == 8) ? int'(x) : (mode == 9) ? int'(y) : 0;
          e_ea = 16'((int'(base) + idx) % 65536);
          e_cross = (int'(base[7:0]) + idx) > 255;
        end
      end
      11, 12: begin
        b = rd_byte(pc); reads.push_back(pc); e_pc = pc + 16'd1;
        z = (mode == 11) ? b + x : b;
        reads.push_back({8'h00, z}); reads.push_back({8'h00, z + 8'd1});
        ptr = {rd_byte({8'h00, z + 8'd1}), rd_byte({8'h00, z})};
        if (mode == 12) begin
          e_ea = 16'((int'(ptr) + int'(y)) % 65536);
          e_cross = (int'(ptr[7:0]) + int'(y)) > 255;
        end else e_ea = ptr;
      end
      default: ;
    endcase
    if (mode >= 2 && mode <= 12 && mode != 6) begin
      reads.push_back(e_ea);
      e_op = rd_byte(e_ea);
    end
    lat = reads.size() + 1;

    @(negedge clk);
    start = 1; mode_i = 4'(mode); pc_i = pc; x_i = x; y_i = y; a_i = a;
    for (int cyc = 1; cyc <= lat; cyc++) begin
      @(negedge clk);
      chk("R1", "busy", busy, 1);
      chk("R2", "done timing", done, (cyc == lat));
      chk("R14", "mem_rd", mem_rd, (cyc < lat));
      if (cyc < lat) chk(req, "read address", mem_addr, reads[cyc-1]);
      if (cyc == lat) begin
        chk(req, "ea", ea, e_ea);
        chk(req, "operand", operand, e_op);
        chk(req, "pc_out", pc_out, e_pc);
        chk("R5", "acc_sel", acc_sel, e_acc);
        chk("R13", "page_cross", page_cross, e_cross);
        start = 0;
      end else if (noisy) begin
        start = 1; mode_i = ~mode_i; pc_i = pc_i ^ 16'h5A5A; x_i = ~x_i; y_i = y_i + 8'd3;
      end else begin
        start = 0;
      end
    end
    @(negedge clk);
    chk("R2", "idle after done", {busy, done}, 2'b00);
    chk("R2", "ea held", ea, e_ea);
  endtask

  task automatic summary;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset busy", busy, 0);
    chk("R2", "reset done", done, 0);
    chk("R14", "reset mem_rd", mem_rd, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);

    run_op("R4", 0, 16'h1234, 8'h11, 8'h22, 8'h33, 0);
    run_op("R4", 14, 16'h0777, 8'h01, 8'h02, 8'h03, 0);
    run_op("R5", 1, 16'h0400, 8'h00, 8'h00, 8'h3C, 0);
    run_op("R6", 2, 16'h2000, 8'h00, 8'h00, 8'h00, 0);

    ovr[16'h3000] = 8'h44;
    run_op("R7", 3, 16'h3000, 8'h00, 8'h00, 8'h00, 0);
    ovr[16'h3001] = 8'hF0;
    run_op("R7", 4, 16'h3001, 8'h20, 8'h00, 8'h00, 0);
    ovr[16'h3002] = 8'h80;
    run_op("R7", 5, 16'h3002, 8'h00, 8'h7F, 8'h00, 0);

    ovr[16'h3100] = 8'h85;
    run_op("R8", 6, 16'h3100, 8'h00, 8'h00, 8'h00, 0);
    ovr[16'h3101] = 8'h12;
    run_op("R8", 6, 16'h3101, 8'h00, 8'h00, 8'h00, 0);

    ovr[16'h4000] = 8'h34; ovr[16'h4001] = 8'h12;
    run_op("R9", 7, 16'h4000, 8'h00, 8'h00, 8'h00, 0);
    ovr[16'h4002] = 8'hF0; ovr[16'h4003] = 8'h12;
    run_op("R13", 8, 16'h4002, 8'h20, 8'h00, 8'h00, 0);
    ovr[16'h4004] = 8'h10; ovr[16'h4005] = 8'h22;
    run_op("R9", 9, 16'h4004, 8'h00, 8'h05, 8'h00, 0);
    ovr[16'hFFFF] = 8'hF0; ovr[16'h0000] = 8'hFF;
    run_op("R9", 8, 16'hFFFF, 8'h20, 8'h00, 8'h00, 0);
    ovr.delete();

    ovr[16'h5000] = 8'hFF; ovr[16'h5001] = 8'h12;
    ovr[16'h12FF] = 8'h78; ovr[16'h1200] = 8'h56; ovr[16'h1300] = 8'h99;
    run_op("R10", 10, 16'h5000, 8'h00, 8'h00, 8'h00, 0);
    ovr.delete();

    ovr[16'h6000] = 8'hFE; ovr[16'h00FF] = 8'h34; ovr[16'h0000] = 8'h12; ovr[16'h0100] = 8'hEE;
    run_op("R11", 11, 16'h6000, 8'h01, 8'h00, 8'h00, 0);
    ovr.delete();

    ovr[16'h6100] = 8'hFF; ovr[16'h00FF] = 8'hF0; ovr[16'h0000] = 8'h20; ovr[16'h0100] = 8'hEE;
    run_op("R12", 12, 16'h6100, 8'h00, 8'h20, 8'h00, 0);
    run_op("R1", 12, 16'h6100, 8'h00, 8'h20, 8'h00, 1);
    run_op("R3", 10, 16'h6100, 8'h00, 8'h00, 8'h00, 1);
    ovr.delete();

    finished = 1;
    summary();
    $finish;
  end

endmodule